// File: doc/BRIEF.md
# Wiper Register Bank Command Executor

This block holds the digital state behind a 256-position potentiometer. It keeps one 8-bit volatile wiper position register and a file of sixteen 8-bit data registers, organised as four banks of four. A serial front end decodes each frame and presents it as one command: an opcode, a bank pointer, a register pointer and a write byte. The executor applies that command and returns a read byte when the command asks for one. It also drives the wiper position straight out to the tap decoder.

Only bank 0 can trade values with the wiper register. The other three banks serve as plain byte storage for the host. Writes into the data register file are not committed at once. The block hands each of them to an external store sequencer, which models the slow nonvolatile programming time and returns a commit pulse when it is done. Until that pulse arrives, the status command reports a write in progress. After reset, the wiper is reloaded from register 0 of bank 0. A step mode moves the wiper one position at a time in response to pulses from the front end.

Top module: `wiper_bank_exec`

## Requirements
- R1: While rst_n is low, every output is 0. After rst_n rises, the core leaves reset on the second clock edge. The next edge copies bank 0 register 0 into wiper_pos, and that register resets to DR0_INIT (default 80h); the other fifteen reset to 00h. Commands offered on that reload edge are dropped.
- R2: Opcode 1010 with bank 0 loads cmd_wdata into wiper_pos on the accepting edge. Opcode 1001 with bank 0 returns the pre-edge wiper_pos on rd_data, with rd_valid high for the one cycle after that edge. rd_data is 00h whenever rd_valid is low.
- R3: Opcode 1100 does not change the register file. If no store is pending, the next cycle carries a one-cycle st_req pulse with st_addr = {cmd_bank, cmd_reg} (bank in the upper two bits) and st_data = cmd_wdata. Both values hold until the next accepted store.
- R4: Opcode 1011 returns the committed content of register {cmd_bank, cmd_reg} for any bank.
- R5: Opcode 1101 with bank 0 copies bank 0 register cmd_reg into wiper_pos.
- R6: Opcode 1110 with bank 0 starts a store of the pre-edge wiper_pos to address {00, cmd_reg}, with the same st_req timing as R3.
- R7: Opcodes 1001, 1010, 1101, 1110 and 0010 carrying a nonzero bank are ignored. No rd_valid, no st_req and no wiper change follow.
- R8: Opcode 0010 with bank 0 arms step mode, and any other accepted command disarms it. While armed, a step_valid pulse moves wiper_pos by +1 when step_up is 1 and by -1 when it is 0. The position saturates at FFh and at 00h.
- R9: Opcode 0101 returns {7'b0, wip}. wip is 1 from the edge that accepts a store until the edge that sees st_commit.
- R10: A store command (1100 or 1110) that arrives while a store is pending is ignored. st_commit with no store pending changes nothing.
- R11: Opcodes outside the eight listed have no effect other than disarming step mode. A step pulse in the same cycle as cmd_valid is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_bank | input | 2 | Bank pointer |
| cmd_reg | input | 2 | Register pointer within the bank |
| cmd_wdata | input | 8 | Write byte |
| step_valid | input | 1 | One wiper step pulse |
| step_up | input | 1 | Step direction, 1 toward FFh |
| st_commit | input | 1 | Store sequencer finished programming |
| rd_valid | output | 1 | rd_data carries a read result |
| rd_data | output | 8 | Read result |
| wiper_pos | output | 8 | Current wiper position |
| st_req | output | 1 | Start a store, one cycle |
| st_addr | output | 4 | Store target register {bank, reg} |
| st_data | output | 8 | Store value |

## Verification
The assertions assume that the front end never raises step_valid together with cmd_valid when it expects a step to land. They also assume the store sequencer raises st_commit only after a request it received. Both assumptions hold even when the stimulus breaks them on purpose, because of the priority rules in R11 and R10. The stimulus sends commands only after the reload edge, except in one deliberate case. It pairs every commit with an earlier request, except where it tests a stray commit. A behavioural model tracks pending stores, arming and saturation, and the bench compares against it every cycle.

// File: rtl/wbe_pkg.sv
package wbe_pkg;

  typedef enum logic [3:0] {
    OP_STEP_MODE  = 4'b0010,
    OP_STATUS     = 4'b0101,
    OP_RD_WIPER   = 4'b1001,
    OP_WR_WIPER   = 4'b1010,
    OP_RD_REG     = 4'b1011,
    OP_WR_REG     = 4'b1100,
    OP_REG2WIPER  = 4'b1101,
    OP_WIPER2REG  = 4'b1110
  } wbe_op_e;

  typedef struct packed {
    logic accepted;
    logic rd_wiper;
    logic wr_wiper;
    logic rd_reg;
    logic wr_reg;
    logic reg2wiper;
    logic wiper2reg;
    logic arm_step;
    logic rd_status;
  } wbe_act_t;

endpackage

// File: rtl/wbe_decode.sv
module wbe_decode
  import wbe_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              enable,
  output wbe_act_t          act
);

  logic go;
  logic bank0;

  always_comb begin
    go    = cmd_valid && enable;
    bank0 = (cmd_bank == '0);
    act   = '0;
    act.accepted = go;
    if (go) begin
      case (cmd_op)
        OP_RD_WIPER:  act.rd_wiper  = bank0;
        OP_WR_WIPER:  act.wr_wiper  = bank0;
        OP_RD_REG:    act.rd_reg    = 1'b1;
        OP_WR_REG:    act.wr_reg    = 1'b1;
        OP_REG2WIPER: act.reg2wiper = bank0;
        OP_WIPER2REG: act.wiper2reg = bank0;
        OP_STEP_MODE: act.arm_step  = bank0;
        OP_STATUS:    act.rd_status = 1'b1;
        default:      act.accepted  = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/wbe_regfile.sv
module wbe_regfile #(
  parameter int          DW      = 8,
  parameter int          NREGS   = 16,
  parameter logic [DW-1:0] DR0_INIT = 8'h80,
  localparam int         AW      = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] home_data
);

  logic [DW-1:0] cell_q [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_cell
    localparam logic [DW-1:0] RST_VAL = (i == 0) ? DR0_INIT : '0;
    logic cell_en;
    assign cell_en = wr_en && (wr_addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q[i] <= RST_VAL;
      end else if (cell_en) begin
        cell_q[i] <= wr_data;
      end
    end
  end

  assign rd_data   = cell_q[rd_addr];
  assign home_data = cell_q[0];

endmodule

// File: rtl/wbe_wiper.sv
module wbe_wiper #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          recall,
  input  logic [DW-1:0] recall_val,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          step,
  input  logic          step_up,
  output logic [DW-1:0] pos
);

  localparam logic [DW-1:0] TOP = {DW{1'b1}};

  logic [DW-1:0] pos_q;
  logic [DW-1:0] pos_d;
  logic          pos_en;

  always_comb begin
    pos_d  = pos_q;
    pos_en = recall || load || step;
    if (recall) begin
      pos_d = recall_val;
    end else if (load) begin
      pos_d = load_val;
    end else if (step) begin
      if (step_up) begin
        if (pos_q != TOP) pos_d = pos_q + 1'b1;
      end else begin
        if (pos_q != '0) pos_d = pos_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_en) begin
      pos_q <= pos_d;
    end
  end

  assign pos = pos_q;

endmodule

// File: rtl/wbe_store.sv
module wbe_store #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_in,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          commit,
  output logic          busy,
  output logic          st_req,
  output logic [AW-1:0] st_addr,
  output logic [DW-1:0] st_data,
  output logic          cell_wr
);

  logic          busy_q, busy_d;
  logic          req_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          accept;
  logic          retire;

  always_comb begin
    accept = req_in && !busy_q;
    retire = commit && busy_q;
    busy_d = busy_q;
    if (accept)      busy_d = 1'b1;
    else if (retire) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      req_q  <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  assign busy    = busy_q;
  assign st_req  = req_q;
  assign st_addr = addr_q;
  assign st_data = data_q;
  assign cell_wr = retire;

endmodule

// File: rtl/wiper_bank_exec.sv
module wiper_bank_exec
  import wbe_pkg::*;
#(
  parameter int            DW       = 8,
  parameter int            NBANK    = 4,
  parameter int            NREG     = 4,
  parameter logic [DW-1:0] DR0_INIT = 8'h80,
  localparam int           BANK_W   = $clog2(NBANK),
  localparam int           REG_W    = $clog2(NREG),
  localparam int           AW       = BANK_W + REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [DW-1:0]     cmd_wdata,
  input  logic              step_valid,
  input  logic              step_up,
  input  logic              st_commit,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     wiper_pos,
  output logic              st_req,
  output logic [AW-1:0]     st_addr,
  output logic [DW-1:0]     st_data
);

  // reset: asserted at once, released through two flops
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic recall_pend;
  logic armed_q, armed_d, armed_en;
  wbe_act_t act;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) recall_pend <= 1'b1;
    else             recall_pend <= 1'b0;
  end

  wbe_decode #(.BANK_W(BANK_W)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .enable    (!recall_pend),
    .act       (act)
  );

  logic [AW-1:0] full_addr;
  logic [AW-1:0] home_addr;
  logic [DW-1:0] rf_rdata;
  logic [DW-1:0] rf_home;
  logic          store_req;
  logic [AW-1:0] store_addr;
  logic [DW-1:0] store_data;
  logic          store_busy;
  logic          cell_wr;
  logic          step_go;
  logic          wiper_load;
  logic [DW-1:0] wiper_load_val;

  assign full_addr = {cmd_bank, cmd_reg};
  assign home_addr = {{BANK_W{1'b0}}, cmd_reg};

  always_comb begin
    store_req  = act.wr_reg || act.wiper2reg;
    store_addr = act.wiper2reg ? home_addr : full_addr;
    store_data = act.wiper2reg ? wiper_pos : cmd_wdata;
    wiper_load     = act.wr_wiper || act.reg2wiper;
    wiper_load_val = act.reg2wiper ? rf_rdata : cmd_wdata;
    step_go    = step_valid && armed_q && !cmd_valid && !recall_pend;
    armed_en   = act.accepted;
    armed_d    = act.arm_step;
  end

  wbe_store #(.DW(DW), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .req_in   (store_req),
    .req_addr (store_addr),
    .req_data (store_data),
    .commit   (st_commit),
    .busy     (store_busy),
    .st_req   (st_req),
    .st_addr  (st_addr),
    .st_data  (st_data),
    .cell_wr  (cell_wr)
  );

  wbe_regfile #(.DW(DW), .NREGS(NBANK*NREG), .DR0_INIT(DR0_INIT)) u_rf (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (cell_wr),
    .wr_addr   (st_addr),
    .wr_data   (st_data),
    .rd_addr   (full_addr),
    .rd_data   (rf_rdata),
    .home_data (rf_home)
  );

  wbe_wiper #(.DW(DW)) u_wiper (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .recall     (recall_pend),
    .recall_val (rf_home),
    .load       (wiper_load),
    .load_val   (wiper_load_val),
    .step       (step_go),
    .step_up    (step_up),
    .pos        (wiper_pos)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)   armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  // read return path
  logic          rv_d;
  logic [DW-1:0] rdat_d;

  always_comb begin
    rv_d   = act.rd_wiper || act.rd_reg || act.rd_status;
    rdat_d = '0;
    if (act.rd_wiper)       rdat_d = wiper_pos;
    else if (act.rd_reg)    rdat_d = rf_rdata;
    else if (act.rd_status) rdat_d = {{(DW-1){1'b0}}, store_busy};
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rv_d;
      rd_data  <= rdat_d;
    end
  end

endmodule

// File: rtl/wbe_chk.sv
module wbe_chk #(
  parameter int DW     = 8,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              recall_pend,
  input logic              cmd_valid,
  input logic [3:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              step_valid,
  input logic              step_up,
  input logic [DW-1:0]     wiper_pos,
  input logic              rd_valid,
  input logic [DW-1:0]     rd_data,
  input logic              st_req
);

  logic live;
  logic far_bank;
  assign live     = cmd_valid && !recall_pend;
  assign far_bank = (cmd_bank != '0);

  // R8
  step_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (step_valid && step_up && !cmd_valid && !recall_pend && wiper_pos == {DW{1'b1}})
    |=> wiper_pos == {DW{1'b1}});

  // R8
  step_floor_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (step_valid && !step_up && !cmd_valid && !recall_pend && wiper_pos == '0)
    |=> wiper_pos == '0);

  // R9
  status_shape_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (live && cmd_op == 4'b0101) |=> (rd_valid && rd_data[DW-1:1] == '0));

  // R7
  far_bank_wiper_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (live && far_bank && (cmd_op == 4'b1010 || cmd_op == 4'b1101 || cmd_op == 4'b0010))
    |=> wiper_pos == $past(wiper_pos));

  // R7
  far_bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (live && far_bank && (cmd_op == 4'b1001 || cmd_op == 4'b1110))
    |=> (!rd_valid && !st_req));

  // R3
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    st_req |=> !st_req);

  // R2
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !rd_valid |-> rd_data == '0);

endmodule

bind wiper_bank_exec wbe_chk #(.DW(DW), .BANK_W(BANK_W)) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .recall_pend (recall_pend),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_bank    (cmd_bank),
  .step_valid  (step_valid),
  .step_up     (step_up),
  .wiper_pos   (wiper_pos),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .st_req      (st_req)
);

// File: tb/wiper_bank_exec_tb.sv
module wiper_bank_exec_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = 4'h0;
  logic [1:0] cmd_bank = 2'd0;
  logic [1:0] cmd_reg = 2'd0;
  logic [7:0] cmd_wdata = 8'h00;
  logic       step_valid = 1'b0;
  logic       step_up = 1'b0;
  logic       st_commit = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [7:0] wiper_pos;
  logic       st_req;
  logic [3:0] st_addr;
  logic [7:0] st_data;

  always #10 clk = ~clk;

  wiper_bank_exec u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .step_valid(step_valid), .step_up(step_up), .st_commit(st_commit),
    .rd_valid(rd_valid), .rd_data(rd_data), .wiper_pos(wiper_pos),
    .st_req(st_req), .st_addr(st_addr), .st_data(st_data)
  );

  // behavioural reference model
  int m_dr [16];
  int m_wcr = 0, m_busy = 0, m_paddr = 0, m_pdata = 0;
  int m_armed = 0, m_recall = 1, m_rs0 = 0, m_rs1 = 0;
  int m_rv = 0, m_rd = 0, m_req = 0;

  int vectors = 0, misses = 0, cycles = 0;
  bit started = 0, done = 0;
  string cur_req = "R1";

  task automatic core_reset();
    for (int i = 0; i < 16; i++) m_dr[i] = (i == 0) ? 'h80 : 0;
    m_wcr = 0; m_busy = 0; m_paddr = 0; m_pdata = 0;
    m_armed = 0; m_recall = 1; m_rv = 0; m_rd = 0; m_req = 0;
  endtask

  initial core_reset();

  always @(posedge clk) begin
    int op, bk, rg, idx, ow, odr_sel, n_rv, n_rd, n_req, accept, ob;
    started = 1;
    if (!rst_n) begin
      m_rs0 = 0; m_rs1 = 0; core_reset();
    end else begin
      if (m_rs1 == 0) begin
        core_reset();
      end else begin
        op = cmd_op; bk = cmd_bank; rg = cmd_reg; idx = bk * 4 + rg;
        ow = m_wcr; ob = m_busy; odr_sel = m_dr[idx];
        n_rv = 0; n_rd = 0; n_req = 0; accept = 0;
        if (m_recall) begin
          m_wcr = m_dr[0];
          m_recall = 0;
        end else if (cmd_valid) begin
          m_armed = (op == 'b0010 && bk == 0);
          case (op)
            'b1001: if (bk == 0) begin n_rv = 1; n_rd = ow; end
            'b1010: if (bk == 0) m_wcr = cmd_wdata;
            'b1011: begin n_rv = 1; n_rd = odr_sel; end
            'b1100: if (!ob) begin accept = 1; m_paddr = idx; m_pdata = cmd_wdata; end
            'b1101: if (bk == 0) m_wcr = odr_sel;
            'b1110: if (bk == 0 && !ob) begin accept = 1; m_paddr = rg; m_pdata = ow; end
            'b0101: begin n_rv = 1; n_rd = ob; end
            default: ;
          endcase
        end else if (step_valid && m_armed) begin
          if (step_up && m_wcr < 255) m_wcr = m_wcr + 1;
          else if (!step_up && m_wcr > 0) m_wcr = m_wcr - 1;
        end
        if (accept) begin
          m_busy = 1; n_req = 1;
        end else if (st_commit && ob) begin
          m_dr[m_paddr] = m_pdata; m_busy = 0;
        end
        m_rv = n_rv; m_rd = n_rd; m_req = n_req;
      end
      m_rs1 = m_rs0; m_rs0 = 1;
    end
  end

  task automatic check(string what, int act, int exp);
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: got %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      check("wiper_pos", wiper_pos, m_wcr);
      check("rd_valid", rd_valid, m_rv);
      check("rd_data", rd_data, m_rd);
      check("st_req", st_req, m_req);
      check("st_addr", st_addr, m_paddr);
      check("st_data", st_data, m_pdata);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog: got %0d cycles expected under 50000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cmd(logic [3:0] op, logic [1:0] bk, logic [1:0] rg, logic [7:0] d);
    cmd_valid = 1; cmd_op = op; cmd_bank = bk; cmd_reg = rg; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0;
    @(negedge clk);
  endtask

  task automatic steps(logic up, int n);
    for (int i = 0; i < n; i++) begin
      step_valid = 1; step_up = up;
      @(negedge clk);
    end
    step_valid = 0;
    @(negedge clk);
  endtask

  task automatic commit();
    st_commit = 1;
    @(negedge clk);
    st_commit = 0;
    @(negedge clk);
  endtask

  initial begin
    int lfsr;
    cur_req = "R1";
    idle(3);
    rst_n = 1;
    idle(5);

    cur_req = "R2";
    cmd(4'b1010, 0, 0, 8'h3C);
    cmd(4'b1001, 0, 0, 8'h00);

    cur_req = "R8";
    cmd(4'b0010, 0, 0, 0);
    steps(1, 5);
    cmd(4'b1010, 0, 0, 8'hFD);
    cmd(4'b0010, 0, 0, 0);
    steps(1, 5);
    cmd(4'b1010, 0, 0, 8'h02);
    cmd(4'b0010, 0, 0, 0);
    steps(0, 5);
    cmd(4'b1001, 0, 0, 0);
    steps(1, 3);

    cur_req = "R3";
    cmd(4'b1100, 2, 1, 8'hA5);
    cur_req = "R9";
    cmd(4'b0101, 1, 0, 0);
    cur_req = "R10";
    cmd(4'b1100, 3, 3, 8'h5A);
    cur_req = "R4";
    cmd(4'b1011, 2, 1, 0);
    commit();
    cmd(4'b1011, 2, 1, 0);
    cmd(4'b1011, 3, 3, 0);
    cur_req = "R9";
    cmd(4'b0101, 0, 0, 0);
    cur_req = "R10";
    commit();

    cur_req = "R5";
    cmd(4'b1100, 0, 3, 8'h77);
    commit();
    cmd(4'b1101, 0, 3, 0);

    cur_req = "R6";
    cmd(4'b1010, 0, 0, 8'h11);
    cmd(4'b1110, 0, 2, 0);
    commit();
    cmd(4'b1011, 0, 2, 0);

    cur_req = "R7";
    cmd(4'b1010, 1, 0, 8'hEE);
    cmd(4'b1101, 2, 3, 0);
    cmd(4'b1110, 3, 1, 0);
    cmd(4'b1001, 1, 0, 0);
    cmd(4'b0010, 1, 0, 0);
    steps(1, 2);

    cur_req = "R11";
    cmd(4'b0000, 0, 0, 8'h99);
    cmd(4'b1111, 0, 0, 8'h99);
    cmd(4'b0010, 0, 0, 0);
    cmd_valid = 1; cmd_op = 4'b0000; step_valid = 1; step_up = 1;
    @(negedge clk);
    cmd_valid = 0; step_valid = 0;
    idle(2);

    cur_req = "R1";
    rst_n = 0;
    idle(2);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 4'b1010; cmd_bank = 0; cmd_wdata = 8'h44;
    @(negedge clk);
    cmd_valid = 0;
    idle(3);

    cur_req = "mix R2 R3 R4 R5 R6 R8 R9";
    lfsr = 32'h1D872B41;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cmd_valid  = lfsr[0] & lfsr[5];
      case (lfsr[3:1])
        0: cmd_op = 4'b1001; 1: cmd_op = 4'b1010; 2: cmd_op = 4'b1011;
        3: cmd_op = 4'b1100; 4: cmd_op = 4'b1101; 5: cmd_op = 4'b1110;
        6: cmd_op = 4'b0010; default: cmd_op = 4'b0101;
      endcase
      cmd_bank   = lfsr[8] & lfsr[9] ? lfsr[7:6] : 2'd0;
      cmd_reg    = lfsr[11:10];
      cmd_wdata  = lfsr[19:12];
      step_valid = lfsr[20];
      step_up    = lfsr[21] | lfsr[22];
      st_commit  = lfsr[23] & lfsr[24];
      @(negedge clk);
    end
    cmd_valid = 0; step_valid = 0; st_commit = 0;
    idle(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule